// File: doc/BRIEF.md
# Single-Cycle 16-Bit Processor Core

This block is a small processor that completes one instruction per clock. It holds a byte-addressed program counter, sixteen 16-bit registers, an ALU steered by a four-line operation code, and private instruction and data memories. A decoder turns the 4-bit opcode into active-high control lines. These lines are register write, a 4-bit ALU code (invert A, negate B, two function bits), store enable, a memory line, branch, jump and halt. The memory line selects three things at once: the register write address, memory or ALU result as write data, and the offset or a register as the second ALU operand.

Every instruction is two bytes long, so every control-flow target is a doubled instruction count. In the assembly operand order the destination comes last: `ADD Ra, Rb, Rd` puts Ra+Rb into Rd. A host loads the program and the initial register values while reset is held low. It then releases reset and waits for the halted flag. After that it reads results through a combinational register-inspection port.

Top module: `cpu16_core`

## Requirements
- R1: While rst_n is low, pc_o is 0 and halted_o is 0. Each non-control-flow instruction that executes at a rising edge leaves pc_o two larger.
- R2: ADD, SUB and AND Ra,Rb,Rd write Ra+Rb, Ra-Rb (modulo 2^16) and Ra&Rb into Rd.
- R3: LW Ra,Rb,k loads Rb from data memory at byte address R[Ra]+k. SW Ra,Rb,k stores R[Rb] there. k is the signed 4-bit field and memory words sit on even addresses.
- R4: BEQ Ra,Rb,k sets the PC to PC+2+2k when R[Ra]==R[Rb], with k signed 4-bit. Otherwise it sets the PC to PC+2.
- R5: JMP n sets the PC to 2n, where n is the 12-bit field [11:0].
- R6: HALT raises halted_o. From then on the PC, the registers and the flag stay frozen until reset.
- R7: R0 always reads 0 and R1 always reads 1. Instruction writes and preload writes to them are ignored.
- R8: Opcodes 8 to 15 change no register or memory and advance the PC by 2.
- R9: The encoding is opcode [15:12] (LW=0, SW=1, ADD=2, SUB=3, AND=4, BEQ=5, JMP=6, HALT=7), Ra [11:8], Rb [7:4], and Rd or k [3:0]. At most one of register write, store, branch, jump and halt is active.
- R10: With rst_n low, pl_imem_we writes pl_imem_data into instruction word pl_imem_addr (byte address twice that), and pl_reg_we writes a register. dbg_data shows register dbg_idx combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; preload window |
| pl_imem_we | input | 1 | Instruction word preload strobe |
| pl_imem_addr | input | IA_W | Instruction word index |
| pl_imem_data | input | 16 | Instruction word to store |
| pl_reg_we | input | 1 | Register preload strobe |
| pl_reg_idx | input | 4 | Register to preload |
| pl_reg_data | input | 16 | Register preload value |
| dbg_idx | input | 4 | Register selected for inspection |
| dbg_data | output | 16 | Contents of register dbg_idx |
| pc_o | output | 16 | Current program counter (byte address) |
| halted_o | output | 1 | Set once HALT has executed |

## Verification
The instruction at pc_o takes effect at the next rising edge. Its register result, its new PC and the halted flag can all be seen one edge after that instruction becomes current. dbg_data follows dbg_idx with no clock. The bench drives and samples on falling edges. Single-step checks come exactly one edge after reset release. Whole-program checks wait for halted_o and then read registers through the inspection port. The frozen state is compared again five edges later.

// File: rtl/cpu16_pkg.sv
package cpu16_pkg;
   localparam int XLEN = 16;
   localparam int NREG = 16;

   localparam logic [3:0] OPC_LW   = 4'd0;
   localparam logic [3:0] OPC_SW   = 4'd1;
   localparam logic [3:0] OPC_ADD  = 4'd2;
   localparam logic [3:0] OPC_SUB  = 4'd3;
   localparam logic [3:0] OPC_AND  = 4'd4;
   localparam logic [3:0] OPC_BEQ  = 4'd5;
   localparam logic [3:0] OPC_JMP  = 4'd6;
   localparam logic [3:0] OPC_HALT = 4'd7;

   // ALU function bits (low two lines of the operation code)
   localparam logic [1:0] FN_AND = 2'b00;
   localparam logic [1:0] FN_OR  = 2'b01;
   localparam logic [1:0] FN_ADD = 2'b10;
   localparam logic [1:0] FN_XOR = 2'b11;

   typedef struct packed {
      logic       inv_a;
      logic       neg_b;
      logic [1:0] fn;
   } alu_op_t;

   typedef struct packed {
      logic    reg_write;
      alu_op_t alu_op;
      logic    mem_store;
      logic    mem;
      logic    branch;
      logic    jump;
      logic    halt;
   } ctrl_t;
endpackage

// File: rtl/cpu16_ctrl.sv
module cpu16_ctrl
   import cpu16_pkg::*;
(
   input  logic [3:0] opcode,
   output ctrl_t      ctl
);
   always_comb begin
      ctl = '0;
      unique case (opcode)
         OPC_LW:   begin ctl.reg_write = 1'b1; ctl.mem = 1'b1; ctl.alu_op.fn = FN_ADD; end
         OPC_SW:   begin ctl.mem_store = 1'b1; ctl.mem = 1'b1; ctl.alu_op.fn = FN_ADD; end
         OPC_ADD:  begin ctl.reg_write = 1'b1; ctl.alu_op.fn = FN_ADD; end
         OPC_SUB:  begin ctl.reg_write = 1'b1; ctl.alu_op.fn = FN_ADD; ctl.alu_op.neg_b = 1'b1; end
         OPC_AND:  begin ctl.reg_write = 1'b1; ctl.alu_op.fn = FN_AND; end
         OPC_BEQ:  begin ctl.branch = 1'b1; ctl.alu_op.fn = FN_ADD; ctl.alu_op.neg_b = 1'b1; end
         OPC_JMP:  ctl.jump = 1'b1;
         OPC_HALT: ctl.halt = 1'b1;
         default:  ctl = '0;
      endcase
   end

   always_comb begin
      AST_CTRL_EXCL: assert ($onehot0({ctl.reg_write, ctl.mem_store, ctl.branch, ctl.jump, ctl.halt})); // R9
   end
endmodule

// File: rtl/cpu16_alu.sv
module cpu16_alu
   import cpu16_pkg::*;
#(
   parameter int W = 16
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  alu_op_t      op,
   output logic [W-1:0] y
);
   if (W < 2) begin : g_bad_w
      $error("cpu16_alu: W must be at least 2");
   end

   logic [W-1:0] a_eff, b_eff;

   always_comb begin
      a_eff = op.inv_a ? ~a : a;
      b_eff = op.neg_b ? ~b : b;
      unique case (op.fn)
         FN_AND:  y = a_eff & b_eff;
         FN_OR:   y = a_eff | b_eff;
         FN_ADD:  y = a_eff + b_eff + W'(op.neg_b);
         default: y = a_eff ^ b_eff;
      endcase
   end
endmodule

// File: rtl/cpu16_regfile.sv
module cpu16_regfile #(
   parameter int W          = 16,
   parameter int N          = 16,
   parameter bit CONST_REGS = 1'b1
) (
   input  logic                 clk,
   input  logic [$clog2(N)-1:0] ra_idx,
   output logic [W-1:0]         ra_val,
   input  logic [$clog2(N)-1:0] rb_idx,
   output logic [W-1:0]         rb_val,
   input  logic [$clog2(N)-1:0] dbg_idx,
   output logic [W-1:0]         dbg_val,
   input  logic                 wr_en,
   input  logic [$clog2(N)-1:0] wr_idx,
   input  logic [W-1:0]         wr_data,
   input  logic                 pl_en,
   input  logic [$clog2(N)-1:0] pl_idx,
   input  logic [W-1:0]         pl_data
);
   localparam int IW = $clog2(N);

   if (N < 2 || (1 << IW) != N) begin : g_bad_n
      $error("cpu16_regfile: N must be a power of two of at least 2");
   end

   logic [N*W-1:0] flat;

   for (genvar i = 0; i < N; i++) begin : g_reg
      if (CONST_REGS && i < 2) begin : g_const
         assign flat[i*W +: W] = W'(i);
      end else begin : g_flop
         logic [W-1:0] q;
         always_ff @(posedge clk) begin
            if (pl_en && pl_idx == IW'(i))
               q <= pl_data;
            else if (wr_en && wr_idx == IW'(i))
               q <= wr_data;
         end
         assign flat[i*W +: W] = q;
      end
   end

   assign ra_val  = flat[ra_idx*W +: W];
   assign rb_val  = flat[rb_idx*W +: W];
   assign dbg_val = flat[dbg_idx*W +: W];
endmodule

// File: rtl/cpu16_core.sv
module cpu16_core
   import cpu16_pkg::*;
#(
   parameter int IMEM_WORDS = 64,
   parameter int DMEM_WORDS = 64,
   parameter bit CONST_REGS = 1'b1,
   localparam int IA_W = $clog2(IMEM_WORDS),
   localparam int DA_W = $clog2(DMEM_WORDS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            pl_imem_we,
   input  logic [IA_W-1:0] pl_imem_addr,
   input  logic [15:0]     pl_imem_data,
   input  logic            pl_reg_we,
   input  logic [3:0]      pl_reg_idx,
   input  logic [15:0]     pl_reg_data,
   input  logic [3:0]      dbg_idx,
   output logic [15:0]     dbg_data,
   output logic [15:0]     pc_o,
   output logic            halted_o
);
   if (IMEM_WORDS < 2 || IMEM_WORDS > 32768 || (1 << IA_W) != IMEM_WORDS) begin : g_bad_imem
      $error("cpu16_core: IMEM_WORDS must be a power of two in 2..32768");
   end
   if (DMEM_WORDS < 2 || DMEM_WORDS > 32768 || (1 << DA_W) != DMEM_WORDS) begin : g_bad_dmem
      $error("cpu16_core: DMEM_WORDS must be a power of two in 2..32768");
   end

   logic [XLEN-1:0] pc_q;
   logic            halted_q;
   logic            run;
   logic [XLEN-1:0] imem [IMEM_WORDS];
   logic [XLEN-1:0] dmem [DMEM_WORDS];
   logic [XLEN-1:0] instr;
   ctrl_t           ctl;

   logic [3:0]      f_ra, f_rb, f_low;
   logic [11:0]     f_imm12;
   logic [XLEN-1:0] off_sext;
   logic [XLEN-1:0] ra_val, rb_val, alu_b, alu_y, ld_data, wb_data;
   logic [3:0]      wb_idx;
   logic            take_branch;
   logic [XLEN-1:0] pc_inc, pc_next;

   assign run   = rst_n && !halted_q;
   assign instr = imem[pc_q[IA_W:1]];

   assign f_ra     = instr[11:8];
   assign f_rb     = instr[7:4];
   assign f_low    = instr[3:0];
   assign f_imm12  = instr[11:0];
   assign off_sext = {{(XLEN-4){f_low[3]}}, f_low};

   cpu16_ctrl u_ctrl (
      .opcode (instr[15:12]),
      .ctl    (ctl)
   );

   cpu16_regfile #(
      .W          (XLEN),
      .N          (NREG),
      .CONST_REGS (CONST_REGS)
   ) u_rf (
      .clk     (clk),
      .ra_idx  (f_ra),
      .ra_val  (ra_val),
      .rb_idx  (f_rb),
      .rb_val  (rb_val),
      .dbg_idx (dbg_idx),
      .dbg_val (dbg_data),
      .wr_en   (run && ctl.reg_write),
      .wr_idx  (wb_idx),
      .wr_data (wb_data),
      .pl_en   (pl_reg_we && !rst_n),
      .pl_idx  (pl_reg_idx),
      .pl_data (pl_reg_data)
   );

   assign alu_b = ctl.mem ? off_sext : rb_val;

   cpu16_alu #(.W(XLEN)) u_alu (
      .a  (ra_val),
      .b  (alu_b),
      .op (ctl.alu_op),
      .y  (alu_y)
   );

   assign ld_data = dmem[alu_y[DA_W:1]];
   assign wb_data = ctl.mem ? ld_data : alu_y;
   assign wb_idx  = ctl.mem ? f_rb : f_low;

   always_ff @(posedge clk) begin
      if (pl_imem_we && !rst_n)
         imem[pl_imem_addr] <= pl_imem_data;
   end

   always_ff @(posedge clk) begin
      if (run && ctl.mem_store)
         dmem[alu_y[DA_W:1]] <= rb_val;
   end

   assign take_branch = ctl.branch && (alu_y == '0);
   assign pc_inc      = pc_q + XLEN'(2);

   always_comb begin
      if (ctl.halt)
         pc_next = pc_q;
      else if (ctl.jump)
         pc_next = XLEN'({f_imm12, 1'b0});
      else if (take_branch)
         pc_next = pc_inc + {off_sext[XLEN-2:0], 1'b0};
      else
         pc_next = pc_inc;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q     <= '0;
         halted_q <= 1'b0;
      end else if (!halted_q) begin
         pc_q     <= pc_next;
         halted_q <= ctl.halt;
      end
   end

   assign pc_o     = pc_q;
   assign halted_o = halted_q;

   AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !ctl.branch && !ctl.jump && !ctl.halt) |=> pc_q == $past(pc_q) + XLEN'(2)); // R1
   AST_BRANCH_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      (run && ctl.branch && ra_val == rb_val) |=>
         pc_q == $past(pc_q) + XLEN'(2) + XLEN'($past({off_sext[XLEN-2:0], 1'b0}))); // R4
   AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      (run && ctl.jump) |=> pc_q == XLEN'({$past(f_imm12), 1'b0})); // R5
   AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      halted_q |=> halted_q && $stable(pc_q)); // R6
endmodule

// File: tb/sim_cpu16_core.sv
`timescale 1ns/1ps
module sim_cpu16_core;
   localparam int IAW = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pl_imem_we = 1'b0;
   logic [IAW-1:0] pl_imem_addr = '0;
   logic [15:0] pl_imem_data = '0;
   logic        pl_reg_we = 1'b0;
   logic [3:0]  pl_reg_idx = '0;
   logic [15:0] pl_reg_data = '0;
   logic [3:0]  dbg_idx = '0;
   logic [15:0] dbg_data;
   logic [15:0] pc_o;
   logic        halted_o;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2 clk = ~clk;

   cpu16_core u0 (
      .clk (clk), .rst_n (rst_n),
      .pl_imem_we (pl_imem_we), .pl_imem_addr (pl_imem_addr), .pl_imem_data (pl_imem_data),
      .pl_reg_we (pl_reg_we), .pl_reg_idx (pl_reg_idx), .pl_reg_data (pl_reg_data),
      .dbg_idx (dbg_idx), .dbg_data (dbg_data), .pc_o (pc_o), .halted_o (halted_o)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic reg_is(input string req, input logic [3:0] idx, input logic [15:0] exp);
      dbg_idx = idx;
      #0.1;
      check(req, dbg_data, exp);
   endtask

   task automatic load_instr(input int word, input logic [15:0] val);
      @(negedge clk);
      pl_imem_we = 1'b1; pl_imem_addr = IAW'(word); pl_imem_data = val;
      @(negedge clk);
      pl_imem_we = 1'b0;
   endtask

   task automatic load_reg(input logic [3:0] idx, input logic [15:0] val);
      @(negedge clk);
      pl_reg_we = 1'b1; pl_reg_idx = idx; pl_reg_data = val;
      @(negedge clk);
      pl_reg_we = 1'b0;
   endtask

   task automatic wait_halt(input string req);
      for (int i = 0; i < 200; i++) begin
         if (halted_o) break;
         @(negedge clk);
      end
      check(req, 16'(halted_o), 16'd1);
   endtask

   // Counting loop: R2 += 1 until R2 == R3, then HALT at 0x06
   task automatic t_count_loop();
      @(negedge clk);
      rst_n = 1'b0;
      load_instr(0, 16'h2212);   // ADD R2,R1,R2
      load_instr(1, 16'h5231);   // BEQ R2,R3,1 -> 0x06
      load_instr(2, 16'h6000);   // JMP 0
      load_instr(3, 16'h7000);   // HALT
      load_reg(4'd2, 16'h0000);
      load_reg(4'd3, 16'h0005);
      load_reg(4'd1, 16'h0055);  // ignored
      load_reg(4'd0, 16'h00AA);  // ignored
      @(negedge clk);
      check("R1 reset pc", pc_o, 16'h0000);
      check("R1 reset halted", 16'(halted_o), 16'd0);
      reg_is("R10 preload R3", 4'd3, 16'h0005);
      reg_is("R7 R1 constant", 4'd1, 16'h0001);
      reg_is("R7 R0 constant", 4'd0, 16'h0000);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 pc step", pc_o, 16'h0002);
      reg_is("R2 ADD result", 4'd2, 16'h0001);
      wait_halt("R6 loop halts");
      check("R4 loop exit pc", pc_o, 16'h0006);
      reg_is("R4 loop R2", 4'd2, 16'h0005);
      reg_is("R4 loop R3", 4'd3, 16'h0005);
   endtask

   // Arithmetic, memory, branches, jump, undefined opcode, frozen halt
   task automatic t_mixed();
      logic [15:0] pc_hold;
      @(negedge clk);
      rst_n = 1'b0;
      load_instr(0,  16'h3457);  // SUB R4,R5,R7
      load_instr(1,  16'h4458);  // AND R4,R5,R8
      load_instr(2,  16'h1672);  // SW  R6,R7,2
      load_instr(3,  16'h0692);  // LW  R6,R9,2
      load_instr(4,  16'h168E);  // SW  R6,R8,-2
      load_instr(5,  16'h06AE);  // LW  R6,R10,-2
      load_instr(6,  16'h2010);  // ADD R0,R1,R0 (ignored write)
      load_instr(7,  16'h211B);  // ADD R1,R1,R11
      load_instr(8,  16'h5455);  // BEQ R4,R5,5 not taken
      load_instr(9,  16'hF123);  // undefined opcode
      load_instr(10, 16'h5001);  // BEQ R0,R0,1 -> 0x18
      load_instr(11, 16'h7000);  // HALT (skipped)
      load_instr(12, 16'h600D);  // JMP 13 -> 0x1A
      load_instr(13, 16'h7000);  // HALT
      load_reg(4'd4, 16'h00F0);
      load_reg(4'd5, 16'h0F3C);
      load_reg(4'd6, 16'h0010);
      @(negedge clk);
      check("R1 re-reset pc", pc_o, 16'h0000);
      check("R1 re-reset halted", 16'(halted_o), 16'd0);
      rst_n = 1'b1;
      @(negedge clk);
      reg_is("R2 SUB result", 4'd7, 16'hF1B4);
      wait_halt("R6 mixed halts");
      check("R5 R4 R8 R9 final pc", pc_o, 16'h001A);
      reg_is("R2 AND result", 4'd8, 16'h0030);
      reg_is("R3 LW positive offset", 4'd9, 16'hF1B4);
      reg_is("R3 LW negative offset", 4'd10, 16'h0030);
      reg_is("R7 R0 write ignored", 4'd0, 16'h0000);
      reg_is("R2 ADD of constants", 4'd11, 16'h0002);
      reg_is("R8 undefined opcode no write", 4'd3, 16'h0005);
      pc_hold = pc_o;
      repeat (5) @(negedge clk);
      check("R6 pc frozen", pc_o, pc_hold);
      check("R6 still halted", 16'(halted_o), 16'd1);
      reg_is("R6 register frozen", 4'd7, 16'hF1B4);
   endtask

   initial begin
      #(4 * 100000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (2) @(negedge clk);
      t_count_loop();
      t_mixed();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule